// File: doc/BRIEF.md
# Serial Port Register Front End with Interrupt Identification

This block is the processor-facing register set of a byte-wide serial port of the classic PC type. A host reaches eight byte registers through a 3-bit offset with separate read and write strobes. A read returns its data in the same cycle as the strobe, and any side effects of the read take place at the clock edge that ends that cycle. A bit in the line-control register swaps the two lowest offsets over to a 16-bit divisor latch.

Received bytes arrive on a valid/ready stream and are held in a receive buffer. The buffer is either one entry deep or sixteen entries deep, depending on whether FIFO mode is on. Bytes written to the data register leave on a one-cycle strobe that is always accepted. In loopback mode those bytes are instead turned back into the receive buffer.

Four interrupt causes are ranked into a single identification code, and a level interrupt output stays high while any enabled cause is pending. Baud generation, serialization and external modem pins are not part of this block.

Top module: `uart_regs`

## Requirements
- R1: When LCR bit 7 is set, offset 0 reads and writes the low divisor byte and offset 1 reads and writes the high divisor byte. Neither access touches the data register or IER. After reset the divisor is 12 (low byte) and 0 (high byte).
- R2: IER (offset 1) stores only write bits 3:0, and bits 7:4 always read 0. The bits are: 0 receive, 1 transmit-empty, 2 line status, 3 modem status.
- R3: When an FCR write (offset 2) changes FCR bit 0, the receive buffer is flushed. Its depth becomes 16 if bit 0 is set and 1 if bit 0 is clear. `rxReady` is low while the buffer holds depth entries.
- R4: An FCR write with bit 0 clear turns FIFO mode off. A write with bits 0 and 1 both set flushes the buffer. IIR bits 7:6 read 11 while FIFO mode is on and 00 otherwise.
- R5: IIR (read at offset 2) bits 3:0 hold the highest-ranked enabled cause. The ranking, from highest, is: overrun 0x6, receive data present 0xC, transmit-empty pending 0x2, modem delta 0x0. With no enabled cause the code is 0x1. `irq` is high exactly when the code is not 0x1.
- R6: A data-register write sets the transmit-empty-pending flag. Outside loopback, the same write drives `txValid` high with `txData` equal to the byte, in that cycle. An IIR read that returns code 0x2 clears the flag.
- R7: LSR (offset 5) reads as 0x60, with bit 1 set for overrun and bit 0 set for a non-empty receive buffer. A read of LSR clears the overrun bit.
- R8: In loopback (MCR bit 4), a data-register write goes into the receive buffer and `txValid` stays low. If the buffer is full, the write sets overrun instead. `rxReady` is low throughout loopback.
- R9: MCR (offset 4) stores only write bits 4:0. In loopback, MSR bits 7:4 reflect MCR bits 3, 2, 0 and 1. An MCR write sets these MSR delta bits: bit 0 when CTS changes, bit 1 when DSR changes, bit 3 when DCD changes, and bit 2 when RI falls. A read of MSR (offset 6) clears bits 3:0.
- R10: Writes to LSR and MSR have no effect. The scratch register (offset 7) reads back the last byte written to it.
- R11: The receive buffer returns bytes in arrival order. A data read of an empty buffer returns 0xFF. A stream push and a data read in the same cycle both take effect.
- R12: After reset, IIR reads 0x01, LSR reads 0x60, IER, LCR and MCR read 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 3 | Register offset |
| wrEn | input | 1 | Write strobe (takes precedence over read) |
| rdEn | input | 1 | Read strobe; side effects at the clock edge |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected offset |
| rxValid | input | 1 | Receive byte offered |
| rxData | input | 8 | Receive byte |
| rxReady | output | 1 | Receive buffer accepts a byte |
| txValid | output | 1 | Transmit byte strobe |
| txData | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt request |

## Verification
Two functions of the receive buffer can fall in the same cycle: a push from the stream, and a pop caused by a data-register read. The bench provokes this by offering a byte on the stream while it reads offset 0 from a non-empty buffer in FIFO mode. It then expects the old head byte in that cycle, the new byte on the next read, and 0xFF after that. The interrupt ranking is provoked a different way: loopback overruns set the overrun, receive and transmit causes together. The bench then peels them off one read at a time.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

  typedef enum logic [3:0] {
    IIR_MODEM = 4'h0,
    IIR_NONE  = 4'h1,
    IIR_TX    = 4'h2,
    IIR_LINE  = 4'h6,
    IIR_RX    = 4'hC
  } iirCode_e;

  typedef enum logic [3:0] {
    SEL_RBR, SEL_IER, SEL_IIR, SEL_LCR, SEL_MCR,
    SEL_LSR, SEL_MSR, SEL_SCR, SEL_DLL, SEL_DLH
  } rdSel_e;

  typedef struct packed {
    logic   wrDll;
    logic   wrDlh;
    logic   wrThr;
    logic   wrIer;
    logic   wrFcr;
    logic   wrLcr;
    logic   wrMcr;
    logic   wrScr;
    logic   rdRbr;
    logic   rdIir;
    logic   rdLsr;
    logic   rdMsr;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/uart_regs_ctrl.sv
module uart_regs_ctrl
  import uart_regs_pkg::*;
(
  input  logic       [2:0] regSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             dlab,
  output regStrobe_t       strb
);

  logic rdGo;
  assign rdGo = rdEn && !wrEn;

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_RBR;
    case (regSel)
      3'd0: begin
        strb.rdSel = dlab ? SEL_DLL : SEL_RBR;
        strb.wrDll = wrEn && dlab;
        strb.wrThr = wrEn && !dlab;
        strb.rdRbr = rdGo && !dlab;
      end
      3'd1: begin
        strb.rdSel = dlab ? SEL_DLH : SEL_IER;
        strb.wrDlh = wrEn && dlab;
        strb.wrIer = wrEn && !dlab;
      end
      3'd2: begin
        strb.rdSel = SEL_IIR;
        strb.wrFcr = wrEn;
        strb.rdIir = rdGo;
      end
      3'd3: begin
        strb.rdSel = SEL_LCR;
        strb.wrLcr = wrEn;
      end
      3'd4: begin
        strb.rdSel = SEL_MCR;
        strb.wrMcr = wrEn;
      end
      3'd5: begin
        strb.rdSel = SEL_LSR;
        strb.rdLsr = rdGo;
      end
      3'd6: begin
        strb.rdSel = SEL_MSR;
        strb.rdMsr = rdGo;
      end
      default: begin
        strb.rdSel = SEL_SCR;
        strb.wrScr = wrEn;
      end
    endcase
  end

endmodule

// File: rtl/uart_regs_dp.sv
module uart_regs_dp
  import uart_regs_pkg::*;
#(
  parameter int RX_DEPTH  = 16,
  parameter int DIV_RESET = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  regStrobe_t strb,
  input  logic [7:0] wrData,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  output logic       rxReady,
  output logic       txValid,
  output logic [7:0] txData,
  output logic [7:0] rdData,
  output logic       irq,
  output logic       dlab
);

  localparam int PTR_W = $clog2(RX_DEPTH);
  localparam int CNT_W = $clog2(RX_DEPTH + 1);
  localparam logic [CNT_W-1:0] DEPTH_FULL = CNT_W'(RX_DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_ONE  = CNT_W'(1);

  logic [7:0]       divLo, divHi, lcr, scr, msr;
  logic [3:0]       ier;
  logic [4:0]       mcr;
  logic             fifoEn, overrun, threPend;
  logic [7:0]       rxMem [RX_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count, curDepth;
  iirCode_e         iirCode;

  logic loop, full, notEmpty, flush, pushStream, pushLoop, ovfLoop, push, pop;
  logic [7:0] pushByte, lsrVal;

  assign dlab       = lcr[7];
  assign loop       = mcr[4];
  assign curDepth   = fifoEn ? DEPTH_FULL : DEPTH_ONE;
  assign full       = count >= curDepth;
  assign notEmpty   = count != '0;
  assign flush      = strb.wrFcr && ((wrData[0] != fifoEn) || (wrData[0] && wrData[1]));
  assign rxReady    = !full && !loop && !flush;
  assign pushStream = rxValid && rxReady;
  assign pushLoop   = strb.wrThr && loop && !full;
  assign ovfLoop    = strb.wrThr && loop && full;
  assign push       = pushStream || pushLoop;
  assign pushByte   = loop ? wrData : rxData;
  assign pop        = strb.rdRbr && notEmpty;
  assign txValid    = strb.wrThr && !loop;
  assign txData     = wrData;
  assign lsrVal     = {1'b0, 1'b1, 1'b1, 3'b000, overrun, notEmpty};

  // receive buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) rxMem[wrPtr] <= pushByte;
  end

  // modem status image for loopback
  logic [3:0] newStat, oldStat, newDelta;
  always_comb begin
    newStat  = loop ? 4'b0 : 4'b0;
    if (wrData[4]) newStat = {wrData[3], wrData[2], wrData[0], wrData[1]};
    oldStat  = msr[7:4];
    newDelta = {newStat[3] ^ oldStat[3],
                oldStat[2] && !newStat[2],
                newStat[1] ^ oldStat[1],
                newStat[0] ^ oldStat[0]};
  end

  // control and status registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divLo    <= 8'(DIV_RESET);
      divHi    <= 8'(DIV_RESET >> 8);
      lcr      <= '0;
      scr      <= '0;
      msr      <= '0;
      ier      <= '0;
      mcr      <= '0;
      fifoEn   <= 1'b0;
      overrun  <= 1'b0;
      threPend <= 1'b0;
    end else begin
      if (strb.wrDll) divLo <= wrData;
      if (strb.wrDlh) divHi <= wrData;
      if (strb.wrLcr) lcr   <= wrData;
      if (strb.wrScr) scr   <= wrData;
      if (strb.wrIer) ier   <= wrData[3:0];
      if (strb.wrFcr) fifoEn <= wrData[0];
      if (strb.wrMcr) begin
        mcr <= wrData[4:0];
        msr <= {newStat, msr[3:0] | newDelta};
      end else if (strb.rdMsr) begin
        msr[3:0] <= '0;
      end
      if (ovfLoop)          overrun <= 1'b1;
      else if (strb.rdLsr)  overrun <= 1'b0;
      if (strb.wrThr)                            threPend <= 1'b1;
      else if (strb.rdIir && iirCode == IIR_TX)  threPend <= 1'b0;
    end
  end

  // ranked interrupt cause
  always_comb begin
    if (overrun && ier[2])          iirCode = IIR_LINE;
    else if (notEmpty && ier[0])    iirCode = IIR_RX;
    else if (threPend && ier[1])    iirCode = IIR_TX;
    else if ((|msr[3:0]) && ier[3]) iirCode = IIR_MODEM;
    else                            iirCode = IIR_NONE;
  end
  assign irq = iirCode != IIR_NONE;

  always_comb begin
    case (strb.rdSel)
      SEL_RBR: rdData = notEmpty ? rxMem[rdPtr] : 8'hFF;
      SEL_IER: rdData = {4'b0, ier};
      SEL_IIR: rdData = {fifoEn, fifoEn, 2'b00, iirCode};
      SEL_LCR: rdData = lcr;
      SEL_MCR: rdData = {3'b0, mcr};
      SEL_LSR: rdData = lsrVal;
      SEL_MSR: rdData = msr;
      SEL_SCR: rdData = scr;
      SEL_DLL: rdData = divLo;
      SEL_DLH: rdData = divHi;
      default: rdData = 8'hFF;
    endcase
  end

  // guards
  assert_fifo_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= curDepth);
  assert_flush_empty_R3: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> count == '0);
  assert_ovr_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdLsr |=> !overrun);
  assert_thre_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdIir && iirCode == IIR_TX) |=> !threPend);
  assert_empty_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdRbr && !notEmpty && !flush) |=> $stable(rdPtr));
  assert_irq_enabled_R5: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ier != 4'b0);

endmodule

// File: rtl/uart_regs.sv
module uart_regs
  import uart_regs_pkg::*;
#(
  parameter int RX_DEPTH  = 16,
  parameter int DIV_RESET = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  output logic       rxReady,
  output logic       txValid,
  output logic [7:0] txData,
  output logic       irq
);

  regStrobe_t strb;
  logic       dlab;

  uart_regs_ctrl u_ctrl (
    .regSel (regSel),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .dlab   (dlab),
    .strb   (strb)
  );

  uart_regs_dp #(
    .RX_DEPTH  (RX_DEPTH),
    .DIV_RESET (DIV_RESET)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .rxValid (rxValid),
    .rxData  (rxData),
    .rxReady (rxReady),
    .txValid (txValid),
    .txData  (txData),
    .rdData  (rdData),
    .irq     (irq),
    .dlab    (dlab)
  );

endmodule

// File: tb/uart_regs_bench.sv
module uart_regs_bench;

  localparam int PERIOD = 10;
  localparam int QTR    = PERIOD / 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regSel = '0;
  logic       wrEn = 1'b0, rdEn = 1'b0, rxValid = 1'b0;
  logic [7:0] wrData = '0, rxData = '0;
  logic [7:0] rdData, txData;
  logic       rxReady, txValid, irq;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #(PERIOD/2) clk = ~clk;

  uart_regs u_uart_regs (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .rxValid(rxValid), .rxData(rxData),
    .rxReady(rxReady), .txValid(txValid), .txData(txData), .irq(irq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    wrEn = 0; rdEn = 0; rxValid = 0;
  endtask

  task automatic wr(logic [2:0] sel, logic [7:0] d);
    @(negedge clk);
    regSel = sel; wrData = d; wrEn = 1; rdEn = 0; rxValid = 0;
  endtask

  task automatic rd(logic [2:0] sel, logic [7:0] exp, string tag);
    @(negedge clk);
    regSel = sel; wrEn = 0; rdEn = 1; rxValid = 0;
    expQ.push_back(exp); tagQ.push_back(tag);
  endtask

  task automatic push(logic [7:0] d);
    @(negedge clk);
    rxData = d; rxValid = 1; wrEn = 0; rdEn = 0;
  endtask

  task automatic pushRead(logic [7:0] d, logic [7:0] exp, string tag);
    @(negedge clk);
    rxData = d; rxValid = 1; wrEn = 0; rdEn = 1; regSel = 3'd0;
    expQ.push_back(exp); tagQ.push_back(tag);
  endtask

  task automatic chkIrq(logic e, string tag);
    idle();
    #(QTR);
    check(tag, {7'b0, irq}, {7'b0, e});
  endtask

  // scoreboard monitor
  always begin
    @(negedge clk);
    #(QTR);
    if (rdEn && !wrEn) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: read with no expectation, actual %02h expected none", rdData);
      end else begin
        check(tagQ.pop_front(), rdData, expQ.pop_front());
      end
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R12 reset state
    rd(2, 8'h01, "R12 iir"); rd(5, 8'h60, "R12 lsr"); rd(1, 8'h00, "R12 ier");
    rd(3, 8'h00, "R12 lcr"); rd(4, 8'h00, "R12 mcr");
    chkIrq(0, "R12 irq");
    // R1 divisor latch
    wr(3, 8'h80);
    rd(0, 8'h0C, "R1 div lo reset"); rd(1, 8'h00, "R1 div hi reset");
    wr(0, 8'h34); #(QTR); check("R1 no tx on latch", {7'b0, txValid}, 8'h00);
    wr(1, 8'h56);
    rd(0, 8'h34, "R1 div lo"); rd(1, 8'h56, "R1 div hi");
    wr(3, 8'h03); rd(3, 8'h03, "R1 lcr"); rd(1, 8'h00, "R1 ier untouched");
    // R2 IER mask
    wr(1, 8'hFF); rd(1, 8'h0F, "R2 ier mask");
    wr(1, 8'h00); rd(1, 8'h00, "R2 ier clear");
    // R10 scratch
    wr(7, 8'h5A); rd(7, 8'h5A, "R10 scratch");
    // R3 depth 1
    push(8'h11); #(QTR); check("R3 ready empty", {7'b0, rxReady}, 8'h01);
    push(8'h22); #(QTR); check("R3 not ready full1", {7'b0, rxReady}, 8'h00);
    rd(5, 8'h61, "R7 lsr data"); rd(0, 8'h11, "R11 byte"); rd(0, 8'hFF, "R11 empty");
    rd(5, 8'h60, "R7 lsr empty");
    // R3/R4 FIFO mode
    wr(2, 8'h01); rd(2, 8'hC1, "R4 iir fifo bits");
    for (int i = 0; i < 16; i++) begin
      push(8'hA0 + 8'(i)); #(QTR); check("R3 ready fifo", {7'b0, rxReady}, 8'h01);
    end
    push(8'hEE); #(QTR); check("R3 not ready full16", {7'b0, rxReady}, 8'h00);
    rd(0, 8'hA0, "R11 order0"); rd(0, 8'hA1, "R11 order1");
    wr(2, 8'h03); rd(5, 8'h60, "R4 rx reset flush"); rd(2, 8'hC1, "R4 still fifo");
    push(8'h33); wr(2, 8'h00);
    rd(5, 8'h60, "R3 toggle flush"); rd(2, 8'h01, "R4 fifo off");
    // R11 same-cycle push and pop
    wr(2, 8'h01); push(8'hB1);
    pushRead(8'hB2, 8'hB1, "R11 pop with push"); #(QTR);
    check("R11 ready during pop", {7'b0, rxReady}, 8'h01);
    rd(0, 8'hB2, "R11 pushed byte"); rd(0, 8'hFF, "R11 empty after");
    // R5 receive interrupt
    wr(1, 8'h01); chkIrq(0, "R5 no cause");
    push(8'h55); chkIrq(1, "R5 rx irq");
    rd(2, 8'hCC, "R5 rx code"); rd(0, 8'h55, "R11 rx byte");
    chkIrq(0, "R5 rx cleared"); rd(2, 8'hC1, "R5 none");
    // R6 transmit
    wr(1, 8'h02); wr(0, 8'h77); #(QTR);
    check("R6 txValid", {7'b0, txValid}, 8'h01); check("R6 txData", txData, 8'h77);
    chkIrq(1, "R6 tx irq");
    rd(2, 8'hC2, "R6 tx code"); rd(2, 8'hC1, "R6 cleared by iir read");
    chkIrq(0, "R6 irq low");
    // R8 loopback and R5 ranking
    wr(2, 8'h00); wr(4, 8'h10); wr(1, 8'h0F);
    rd(2, 8'h01, "R5 loop idle");
    push(8'h99); #(QTR); check("R8 no ready loop", {7'b0, rxReady}, 8'h00);
    wr(0, 8'h41); #(QTR); check("R8 no tx loop", {7'b0, txValid}, 8'h00);
    wr(0, 8'h42);
    rd(2, 8'h06, "R5 line first"); rd(5, 8'h63, "R7 overrun");
    rd(5, 8'h61, "R7 overrun cleared"); rd(2, 8'h0C, "R5 rx second");
    rd(0, 8'h41, "R8 looped byte"); rd(2, 8'h02, "R5 tx third");
    rd(2, 8'h01, "R6 tx cleared");
    // R9 modem image
    wr(4, 8'h11); chkIrq(1, "R9 modem irq");
    rd(2, 8'h00, "R5 modem code"); rd(6, 8'h22, "R9 dsr delta");
    rd(6, 8'h20, "R9 delta cleared"); rd(2, 8'h01, "R9 none");
    // R10 ignored writes
    wr(6, 8'hFF); rd(6, 8'h20, "R10 msr write ignored");
    wr(5, 8'hFF); rd(5, 8'h60, "R10 lsr write ignored");
    wr(4, 8'hFF); rd(4, 8'h1F, "R9 mcr mask"); rd(6, 8'hF9, "R9 rise deltas");
    wr(4, 8'h10); rd(6, 8'h0F, "R9 fall deltas"); rd(6, 8'h00, "R9 cleared");
    wr(1, 8'h00); idle(); idle(); idle();
    check("scoreboard drained", 8'(expQ.size()), 8'h00);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule